// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This control block carries out the hardware share of taking and leaving an exception in a processor core. When an exception request is accepted, it saves the program counter and the status word. For a fast interrupt they go into a pair of backup registers. For every other exception they are pushed onto the interrupt stack. The block then clears the user-stack select, interrupt-enable and processor-mode bits of the status word and reads the handler address through a vector port. It hands the core a new PC, status word and stack pointer in a single update cycle.

Two return requests undo the entry. The fast return takes PC and status word back from the backup registers. The normal return pops them from the stack. After either return, the processor-mode bit of the restored status word selects user or supervisor mode. The PC that is saved depends on the exception class. Cancelled and suspended instructions are re-executed, so the current PC is saved. Completed instructions resume at the next PC.

Timing is counted from the accepting clock edge E0. On the stack path, cycle 1 writes the status word, cycle 2 writes the PC and cycle 3 is the update cycle. The normal return has the same three-cycle shape, with two reads followed by the update. Both fast paths go straight to the update in cycle 1.

Top module: `exc_seq`

## Requirements
- R1: While reset is high, busy, mem_we, mem_re, vec_re and upd_valid are low after the first clock edge, and user_mode is 0.
- R2: A request with kind 7 (fast interrupt) stores the next PC and cur_psw in backup registers. It makes no memory access, and in cycle 1 it gives upd_valid with new_sp equal to cur_sp.
- R3: In every entry update cycle, new_psw equals the saved status word with bits 16 (interrupt enable), 17 (user stack) and 20 (processor mode) cleared and all other bits kept. user_mode is 0 from the next cycle.
- R4: A stack entry writes the status word at cur_sp-4 in cycle 1 and the saved PC at cur_sp-8 in cycle 2. It gives new_sp = cur_sp-8 in cycle 3. At most one memory strobe is high in any cycle.
- R5: In the entry update cycle, vec_re is high, vec_idx equals the accepted kind and new_pc equals vec_data.
- R6: The saved PC is cur_pc for kinds 0, 1 and 2 (cancelling) and for kind 4 (interrupt during a repeat instruction, suspending). It is nxt_pc for kinds 3, 5, 6 and 7 (completing).
- R7: A normal return (ret_valid with ret_fast=0) reads the PC at cur_sp in cycle 1 and the status word at cur_sp+4 in cycle 2. In cycle 3 it gives those values on new_pc and new_psw, with new_sp = cur_sp+8.
- R8: A fast return (ret_valid with ret_fast=1) gives the backup PC and status word in cycle 1 with new_sp = cur_sp and no memory access. Both backup registers reset to 0.
- R9: After a return update, user_mode equals bit 20 of the restored status word.
- R10: busy is high from cycle 1 through the update cycle and low otherwise. Requests and returns presented while busy is high are ignored.
- R11: If an exception request and a return request arrive together while idle, the exception is taken.
- R12: Kind 6 (non-maskable interrupt) uses the stack entry path like any other non-fast exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request |
| req_kind | input | 3 | Exception kind code |
| ret_valid | input | 1 | Return request |
| ret_fast | input | 1 | 1 selects the fast return |
| cur_pc | input | 32 | Address of the current instruction |
| nxt_pc | input | 32 | Address of the next instruction |
| cur_psw | input | 32 | Current status word |
| cur_sp | input | 32 | Current interrupt stack pointer |
| busy | output | 1 | A sequence is in progress |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 32 | Stack byte address |
| mem_wdata | output | 32 | Stack write data |
| mem_rdata | input | 32 | Stack read data, valid in the mem_re cycle |
| vec_re | output | 1 | Vector read strobe |
| vec_idx | output | 3 | Vector index |
| vec_data | input | 32 | Handler address, valid in the vec_re cycle |
| upd_valid | output | 1 | Apply new_pc, new_psw and new_sp |
| new_pc | output | 32 | PC to load |
| new_psw | output | 32 | Status word to load |
| new_sp | output | 32 | Stack pointer to load |
| user_mode | output | 1 | 1 when the core runs in user mode |

## Verification
The bench walks every kind code. A wrong restart-class mapping shows up as the wrong PC word on the stack. It then returns from each frame. Swapped push or pop order, or a stack pointer stepped in the wrong direction, would put the status word where the PC belongs and corrupt the restored state. It holds a request across a busy sequence and raises a return in the same cycle as a request. A design that listened while busy would start a second frame, and one with the wrong arbitration would pop instead of push. Fast entry and fast return are checked for silence on the memory port, and the processor-mode bit is toggled across returns to catch a user_mode that ignores the restored word.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int XLEN       = 32;
    localparam int KIND_W     = 3;
    localparam int WORD_BYTES = XLEN / 8;

    localparam int PSW_IE_BIT = 16;
    localparam int PSW_US_BIT = 17;
    localparam int PSW_PM_BIT = 20;

    typedef enum logic [KIND_W-1:0] {
        K_UNDEF   = 3'd0,
        K_PRIV    = 3'd1,
        K_FPU     = 3'd2,
        K_IRQ     = 3'd3,
        K_IRQ_RPT = 3'd4,
        K_TRAP    = 3'd5,
        K_NMI     = 3'd6,
        K_FAST    = 3'd7
    } exc_kind_e;

    typedef enum logic [1:0] {
        RS_CANCEL,
        RS_SUSPEND,
        RS_COMPLETE
    } restart_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_VECTOR,
        ST_POP_PC,
        ST_POP_SR,
        ST_RESTORE
    } seq_st_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] psw;
    } frame_t;

    function automatic restart_e restart_class(input exc_kind_e k);
        case (k)
            K_UNDEF, K_PRIV, K_FPU: restart_class = RS_CANCEL;
            K_IRQ_RPT:              restart_class = RS_SUSPEND;
            default:                restart_class = RS_COMPLETE;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] entry_psw(input logic [XLEN-1:0] p);
        logic [XLEN-1:0] r;
        r = p;
        r[PSW_IE_BIT] = 1'b0;
        r[PSW_US_BIT] = 1'b0;
        r[PSW_PM_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_seq_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   nxt_pc,
    output logic [XLEN-1:0]   save_pc,
    output logic              use_fast
);
    restart_e cls;

    always_comb begin
        cls      = restart_class(exc_kind_e'(kind));
        use_fast = (exc_kind_e'(kind) == K_FAST);
        case (cls)
            RS_CANCEL, RS_SUSPEND: save_pc = cur_pc;
            default:               save_pc = nxt_pc;
        endcase
    end
endmodule

// File: rtl/exc_backup.sv
module exc_backup
    import exc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cap_en,
    input  frame_t cap_frame,
    output frame_t held_frame
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_frame <= '0;
        end else if (cap_en) begin
            held_frame <= cap_frame;
        end
    end
endmodule

// File: rtl/exc_stack_agu.sv
module exc_stack_agu
    import exc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [XLEN-1:0] load_val,
    input  logic            step_dn,
    input  logic            step_up,
    output logic [XLEN-1:0] sp_q,
    output logic [XLEN-1:0] push_addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= load_val;
        end else if (step_dn) begin
            sp_q <= sp_q - STEP;
        end else if (step_up) begin
            sp_q <= sp_q + STEP;
        end
    end

    assign push_addr = sp_q - STEP;
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              ret_valid,
    input  logic              ret_fast,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   nxt_pc,
    input  logic [XLEN-1:0]   cur_psw,
    input  logic [XLEN-1:0]   cur_sp,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              vec_re,
    output logic [KIND_W-1:0] vec_idx,
    input  logic [XLEN-1:0]   vec_data,
    output logic              upd_valid,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   new_psw,
    output logic [XLEN-1:0]   new_sp,
    output logic              user_mode
);
    seq_st_e           st_q, st_d;
    logic [KIND_W-1:0] kind_q;
    frame_t            work_q, work_d;
    frame_t            bak_frame;
    logic              umode_q;

    logic [XLEN-1:0]   save_pc;
    logic              use_fast;
    logic              take_exc, take_ret;
    logic              bak_cap;
    logic              sp_load, sp_dn, sp_up;
    logic [XLEN-1:0]   sp_q, push_addr;

    exc_classify u_cls (
        .kind     (req_kind),
        .cur_pc   (cur_pc),
        .nxt_pc   (nxt_pc),
        .save_pc  (save_pc),
        .use_fast (use_fast)
    );

    exc_backup u_bak (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (bak_cap),
        .cap_frame  ('{pc: save_pc, psw: cur_psw}),
        .held_frame (bak_frame)
    );

    exc_stack_agu u_agu (
        .clk       (clk),
        .rst       (rst),
        .load      (sp_load),
        .load_val  (cur_sp),
        .step_dn   (sp_dn),
        .step_up   (sp_up),
        .sp_q      (sp_q),
        .push_addr (push_addr)
    );

    assign take_exc = (st_q == ST_IDLE) && req_valid;
    assign take_ret = (st_q == ST_IDLE) && !req_valid && ret_valid;
    assign bak_cap  = take_exc && use_fast;
    assign sp_load  = take_exc || take_ret;
    assign sp_dn    = (st_q == ST_PUSH_SR) || (st_q == ST_PUSH_PC);
    assign sp_up    = (st_q == ST_POP_PC) || (st_q == ST_POP_SR);

    always_comb begin
        st_d   = st_q;
        work_d = work_q;
        case (st_q)
            ST_IDLE: begin
                if (take_exc) begin
                    work_d = '{pc: save_pc, psw: cur_psw};
                    st_d   = use_fast ? ST_VECTOR : ST_PUSH_SR;
                end else if (take_ret) begin
                    if (ret_fast) begin
                        work_d = bak_frame;
                        st_d   = ST_RESTORE;
                    end else begin
                        st_d   = ST_POP_PC;
                    end
                end
            end
            ST_PUSH_SR: st_d = ST_PUSH_PC;
            ST_PUSH_PC: st_d = ST_VECTOR;
            ST_VECTOR:  st_d = ST_IDLE;
            ST_POP_PC: begin
                work_d.pc = mem_rdata;
                st_d      = ST_POP_SR;
            end
            ST_POP_SR: begin
                work_d.psw = mem_rdata;
                st_d       = ST_RESTORE;
            end
            ST_RESTORE: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            work_q  <= '0;
            kind_q  <= '0;
            umode_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            work_q <= work_d;
            if (take_exc) begin
                kind_q <= req_kind;
            end
            if (st_q == ST_VECTOR) begin
                umode_q <= 1'b0;
            end else if (st_q == ST_RESTORE) begin
                umode_q <= work_q.psw[PSW_PM_BIT];
            end
        end
    end

    always_comb begin
        busy      = (st_q != ST_IDLE);
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        vec_re    = 1'b0;
        vec_idx   = '0;
        upd_valid = 1'b0;
        new_pc    = '0;
        new_psw   = '0;
        new_sp    = '0;
        case (st_q)
            ST_PUSH_SR: begin
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = work_q.psw;
            end
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = work_q.pc;
            end
            ST_POP_PC, ST_POP_SR: begin
                mem_re   = 1'b1;
                mem_addr = sp_q;
            end
            ST_VECTOR: begin
                vec_re    = 1'b1;
                vec_idx   = kind_q;
                upd_valid = 1'b1;
                new_pc    = vec_data;
                new_psw   = entry_psw(work_q.psw);
                new_sp    = sp_q;
            end
            ST_RESTORE: begin
                upd_valid = 1'b1;
                new_pc    = work_q.pc;
                new_psw   = work_q.psw;
                new_sp    = sp_q;
            end
            default: ;
        endcase
    end

    assign user_mode = umode_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
    import exc_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            mem_we,
    input logic            mem_re,
    input logic [XLEN-1:0] mem_addr,
    input logic            vec_re,
    input logic            upd_valid,
    input logic [XLEN-1:0] new_psw,
    input logic            user_mode
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re) && !(vec_re && (mem_we || mem_re)));

    assert_push_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - STEP));

    assert_pop_step_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + STEP));

    assert_entry_clear_R3: assert property (@(posedge clk) disable iff (rst)
        vec_re |-> (!new_psw[PSW_IE_BIT] && !new_psw[PSW_US_BIT] && !new_psw[PSW_PM_BIT]));

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> !busy);

    assert_act_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re || vec_re || upd_valid) |-> busy);

    assert_umode_follow_R9: assert property (@(posedge clk) disable iff (rst)
        $past(upd_valid) |-> (user_mode == $past(new_psw[PSW_PM_BIT])));
endmodule

bind exc_seq exc_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .vec_re    (vec_re),
    .upd_valid (upd_valid),
    .new_psw   (new_psw),
    .user_mode (user_mode)
);

// File: tb/exc_seq_tb_top.sv
`timescale 1ns/1ps
module exc_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic        ret_valid = 1'b0;
    logic        ret_fast = 1'b0;
    logic [31:0] cur_pc = '0, nxt_pc = '0, cur_psw = '0, cur_sp = '0;
    logic        busy, mem_we, mem_re, vec_re, upd_valid, user_mode;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, vec_data;
    logic [2:0]  vec_idx;
    logic [31:0] new_pc, new_psw, new_sp;

    logic [31:0] mem [0:255];

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];
    assign vec_data  = 32'h0000_8000 | {25'd0, vec_idx, 4'd0};

    exc_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .ret_valid(ret_valid), .ret_fast(ret_fast), .cur_pc(cur_pc),
        .nxt_pc(nxt_pc), .cur_psw(cur_psw), .cur_sp(cur_sp), .busy(busy),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .vec_re(vec_re),
        .vec_idx(vec_idx), .vec_data(vec_data), .upd_valid(upd_valid),
        .new_pc(new_pc), .new_psw(new_psw), .new_sp(new_sp),
        .user_mode(user_mode)
    );

    typedef struct {
        bit          busy, we, re, vre, upd, pm;
        logic [31:0] addr, wdata, npc, npsw, nsp;
        logic [2:0]  vidx;
        string       tag;
    } exp_t;

    exp_t        q[$];
    exp_t        cur;
    bit          m_um;
    logic [31:0] m_bpc, m_bpsw;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;
    bit          seen_edge = 0;

    function automatic exp_t idle_rec();
        exp_t e;
        e.busy = 0; e.we = 0; e.re = 0; e.vre = 0; e.upd = 0; e.pm = 0;
        e.addr = 0; e.wdata = 0; e.npc = 0; e.npsw = 0; e.nsp = 0; e.vidx = 0;
        e.tag = "R10";
        return e;
    endfunction

    function automatic logic [31:0] clr_bits(logic [31:0] p);
        return p & ~32'h0013_0000;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: advances one cycle per clock edge
    always @(posedge clk) begin
        exp_t e;
        logic [31:0] spc;
        string t;
        cycles++;
        seen_edge = 1;
        if (rst) begin
            q.delete();
            cur = idle_rec();
            m_um = 0; m_bpc = 0; m_bpsw = 0;
        end else begin
            if (cur.upd) m_um = cur.pm;
            if (cur.we) mem[cur.addr[9:2]] = cur.wdata;
            if (q.size() > 0) begin
                cur = q.pop_front();
            end else if (!cur.busy && req_valid) begin
                spc = (req_kind inside {3'd0, 3'd1, 3'd2, 3'd4}) ? cur_pc : nxt_pc;
                t = ret_valid ? "R11" : (req_kind == 3'd6) ? "R12" : "R4";
                if (req_kind != 3'd7) begin
                    e = idle_rec(); e.busy = 1; e.tag = t;
                    e.we = 1; e.addr = cur_sp - 4; e.wdata = cur_psw;
                    q.push_back(e);
                    e.addr = cur_sp - 8; e.wdata = spc; e.tag = "R6";
                    q.push_back(e);
                    e = idle_rec(); e.busy = 1; e.tag = "R5";
                    e.vre = 1; e.vidx = req_kind; e.upd = 1;
                    e.npc = 32'h0000_8000 | {25'd0, req_kind, 4'd0};
                    e.npsw = clr_bits(cur_psw); e.nsp = cur_sp - 8; e.pm = 0;
                    q.push_back(e);
                end else begin
                    m_bpc = spc; m_bpsw = cur_psw;
                    e = idle_rec(); e.busy = 1; e.tag = "R2";
                    e.vre = 1; e.vidx = 3'd7; e.upd = 1;
                    e.npc = 32'h0000_8070; e.npsw = clr_bits(cur_psw);
                    e.nsp = cur_sp; e.pm = 0;
                    q.push_back(e);
                end
                cur = q.pop_front();
            end else if (!cur.busy && ret_valid) begin
                if (!ret_fast) begin
                    e = idle_rec(); e.busy = 1; e.tag = "R7";
                    e.re = 1; e.addr = cur_sp;
                    q.push_back(e);
                    e.addr = cur_sp + 4;
                    q.push_back(e);
                    e = idle_rec(); e.busy = 1; e.tag = "R7"; e.upd = 1;
                    e.npc = mem[cur_sp[9:2]]; e.npsw = mem[(cur_sp + 4) >> 2 & 32'hFF];
                    e.nsp = cur_sp + 8; e.pm = e.npsw[20];
                    q.push_back(e);
                end else begin
                    e = idle_rec(); e.busy = 1; e.tag = "R8"; e.upd = 1;
                    e.npc = m_bpc; e.npsw = m_bpsw; e.nsp = cur_sp; e.pm = m_bpsw[20];
                    q.push_back(e);
                end
                cur = q.pop_front();
            end else begin
                cur = idle_rec();
            end
        end
        if (cycles > 100000) begin
            chk(0, "R10", "watchdog", 0, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (seen_edge) begin
            if (rst) begin
                chk(!busy && !mem_we && !mem_re && !vec_re && !upd_valid, "R1", "idle outputs",
                    {27'd0, busy, mem_we, mem_re, vec_re, upd_valid}, 0);
                chk(user_mode == 0, "R1", "user_mode", 32'(user_mode), 0);
            end else begin
                chk(busy == cur.busy, cur.tag, "busy", 32'(busy), 32'(cur.busy));
                chk(mem_we == cur.we, cur.tag, "mem_we", 32'(mem_we), 32'(cur.we));
                chk(mem_re == cur.re, cur.tag, "mem_re", 32'(mem_re), 32'(cur.re));
                chk(vec_re == cur.vre, cur.tag, "vec_re", 32'(vec_re), 32'(cur.vre));
                chk(upd_valid == cur.upd, cur.tag, "upd_valid", 32'(upd_valid), 32'(cur.upd));
                if (cur.we || cur.re)
                    chk(mem_addr == cur.addr, cur.tag, "mem_addr", mem_addr, cur.addr);
                if (cur.we)
                    chk(mem_wdata == cur.wdata, cur.tag, "mem_wdata", mem_wdata, cur.wdata);
                if (cur.vre)
                    chk(vec_idx == cur.vidx, "R5", "vec_idx", 32'(vec_idx), 32'(cur.vidx));
                if (cur.upd) begin
                    chk(new_pc == cur.npc, cur.tag, "new_pc", new_pc, cur.npc);
                    chk(new_psw == cur.npsw, cur.vre ? "R3" : cur.tag, "new_psw", new_psw, cur.npsw);
                    chk(new_sp == cur.nsp, cur.tag, "new_sp", new_sp, cur.nsp);
                end
                chk(user_mode == m_um, "R9", "user_mode", 32'(user_mode), 32'(m_um));
            end
        end
    end

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raise_exc(logic [2:0] k, logic [31:0] pc, logic [31:0] psw, logic [31:0] sp);
        @(negedge clk);
        req_valid = 1; req_kind = k; cur_pc = pc; nxt_pc = pc + 4;
        cur_psw = psw; cur_sp = sp;
        @(negedge clk);
        req_valid = 0;
        gap(4);
    endtask

    task automatic raise_ret(bit fast, logic [31:0] sp);
        @(negedge clk);
        ret_valid = 1; ret_fast = fast; cur_sp = sp;
        @(negedge clk);
        ret_valid = 0;
        gap(4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        gap(3);
        rst = 0;
        gap(2);
        // R6 cancel kind with every mode bit set, then a normal return (R9 -> 1)
        raise_exc(3'd0, 32'h0000_0100, 32'h0013_00A5, 32'h0000_0300);
        raise_ret(0, 32'h0000_02F8);
        // every non-fast kind, alternating PM so user_mode toggles
        for (int k = 1; k < 7; k++) begin
            logic [31:0] sp;
            sp = 32'h0000_0380 - 32'(k * 16);
            raise_exc(3'(k), 32'h0000_0200 + 32'(k * 32),
                      ((k % 2) ? 32'h0010_0000 : 32'h0002_0000) | 32'(k), sp);
            raise_ret(0, sp - 8);
        end
        // R2 fast entry and R8 fast return, PM clear then set
        raise_exc(3'd7, 32'h0000_0500, 32'h0003_0011, 32'h0000_03F0);
        raise_ret(1, 32'h0000_03F0);
        raise_exc(3'd7, 32'h0000_0600, 32'h0010_0042, 32'h0000_03E0);
        raise_ret(1, 32'h0000_03E0);
        // R10 request held across a busy sequence, return raised mid-sequence
        @(negedge clk);
        req_valid = 1; req_kind = 3'd3; cur_pc = 32'h700; nxt_pc = 32'h704;
        cur_psw = 32'h0011_0007; cur_sp = 32'h0000_0340;
        @(negedge clk);
        req_kind = 3'd5; cur_pc = 32'h900;
        ret_valid = 1; ret_fast = 1;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        ret_valid = 0;
        gap(4);
        raise_ret(0, 32'h0000_0338);
        // R11 request and return in the same idle cycle
        @(negedge clk);
        req_valid = 1; req_kind = 3'd6; cur_pc = 32'hA00; nxt_pc = 32'hA04;
        cur_psw = 32'h0010_0003; cur_sp = 32'h0000_0320;
        ret_valid = 1; ret_fast = 0;
        @(negedge clk);
        req_valid = 0; ret_valid = 0;
        gap(4);
        raise_ret(0, 32'h0000_0318);
        gap(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule